// File: doc/BRIEF.md
# Exclusive Access Monitor

This block is the local reservation tracker that sits beside one processor's load/store path for memory that no other processor touches. A load-exclusive records the address it read and arms the monitor. A later store-exclusive may reach memory only while the monitor is still armed for that same address. Any successful store-exclusive disarms it. A store-exclusive that comes after another control path has already completed its own exclusive pair therefore fails, and the software loop runs its read-modify-write again.

The monitor keeps one reservation address and a two-state machine with the states open and armed. A dedicated clear strobe disarms the monitor, for example when an exception handler returns. Each accepted store-exclusive produces a one-cycle done pulse one clock later. The pulse carries a status bit, 0 for success and 1 for failure, together with a gated write strobe, address and data toward memory. Addresses are compared at the granularity of a reservation granule, whose size is set by a parameter.

Top module: `xmon_top`

## Requirements
- R1: After reset the monitor is open. No store-exclusive can succeed until a load-exclusive has been accepted, and `mem_we` and `stx_done` are 0.
- R2: An accepted load-exclusive records its address and arms the monitor. A following store-exclusive to that address succeeds: one cycle after its strobe, `stx_done`=1, `stx_status`=0 and `mem_we`=1, with `mem_waddr`/`mem_wdata` equal to the store's address and data.
- R3: After a successful store-exclusive the monitor is open again, so a second store-exclusive with no new load-exclusive fails.
- R4: A store-exclusive accepted while the monitor is open gives `stx_done`=1, `stx_status`=1 and `mem_we`=0 one cycle later.
- R5: A load-exclusive accepted while the monitor is armed keeps it armed and replaces the reservation address. A store to the old address then fails, and a store to the new address succeeds.
- R6: A store-exclusive whose address lies outside the reserved granule fails with status 1 and opens the monitor. A later store to the reserved address also fails.
- R7: Two addresses that differ only in their low `GRAN_W` bits fall in the same granule and count as a match.
- R8: A `clrx` strobe opens the monitor, so a following store-exclusive fails.
- R9: At most one strobe is accepted per cycle, with priority `clrx` > store-exclusive > load-exclusive. A dropped store gives no `stx_done`, and a dropped load does not arm the monitor.
- R10: `stx_done`, `stx_status` and `mem_we` appear exactly one cycle after an accepted store-exclusive and last a single cycle.
- R11: When two control paths interleave (load A, load A, store A, store A), the second path's store succeeds, the first path's store fails, and the first path's retry succeeds. Memory ends up holding both increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ldx_valid | input | 1 | Load-exclusive strobe |
| ldx_addr | input | ADDR_W | Load-exclusive address |
| stx_valid | input | 1 | Store-exclusive strobe |
| stx_addr | input | ADDR_W | Store-exclusive address |
| stx_data | input | DATA_W | Store-exclusive data |
| clrx | input | 1 | Clear reservation strobe |
| mem_we | output | 1 | Gated write enable toward memory |
| mem_waddr | output | ADDR_W | Write address toward memory |
| mem_wdata | output | DATA_W | Write data toward memory |
| stx_done | output | 1 | Store-exclusive result valid |
| stx_status | output | 1 | 0 = store committed, 1 = store failed |

## Verification
The bench builds the monitor with ADDR_W=12, DATA_W=16 and GRAN_W=2, which gives a four-byte reservation granule. With that granule, addresses that differ only in their byte offset must match, and an address one word away must miss. That pair of cases exercises the masked compare from both sides. The narrow data path keeps the bench's small memory model cheap, so the interleaved retry can be checked against the final memory contents. It can also be checked against the status bits.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  typedef enum logic {
    MON_OPEN  = 1'b0,
    MON_ARMED = 1'b1
  } mon_state_e;
endpackage

// File: rtl/xmon_arb.sv
// Strobe acceptance: clear beats store, store beats load.
module xmon_arb (
  input  logic ldx_valid,
  input  logic stx_valid,
  input  logic clrx,
  output logic clr_acc,
  output logic stx_acc,
  output logic ldx_acc
);
  always_comb begin
    clr_acc = clrx;
    stx_acc = stx_valid & ~clrx;
    ldx_acc = ldx_valid & ~stx_valid & ~clrx;
  end
endmodule

// File: rtl/xmon_tag.sv
// Reservation address register and granule compare.
module xmon_tag #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldx_acc,
  input  logic [ADDR_W-1:0] ldx_addr,
  input  logic [ADDR_W-1:0] stx_addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] CMP_MASK = {ADDR_W{1'b1}} << GRAN_W;

  logic [ADDR_W-1:0] tag_q, tag_d;

  always_comb begin
    tag_d = tag_q;
    if (ldx_acc) tag_d = ldx_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else        tag_q <= tag_d;
  end

  always_comb hit = ~|((tag_q ^ stx_addr) & CMP_MASK);
endmodule

// File: rtl/xmon_fsm.sv
// Two-state open/armed machine deciding store commit.
module xmon_fsm
  import xmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_acc,
  input  logic stx_acc,
  input  logic ldx_acc,
  input  logic hit,
  output logic armed,
  output logic commit
);
  mon_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clr_acc || stx_acc) state_d = MON_OPEN;
    else if (ldx_acc)       state_d = MON_ARMED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MON_OPEN;
    else        state_q <= state_d;
  end

  always_comb begin
    armed  = (state_q == MON_ARMED);
    commit = stx_acc & armed & hit;
  end

  assert_load_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ldx_acc |=> state_q == MON_ARMED);
  assert_store_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stx_acc |=> state_q == MON_OPEN);
  assert_clear_opens_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_acc |=> state_q == MON_OPEN);
endmodule

// File: rtl/xmon_resp.sv
// Registered response: done/status pulse and gated memory write.
module xmon_resp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stx_acc,
  input  logic              commit,
  input  logic [ADDR_W-1:0] stx_addr,
  input  logic [DATA_W-1:0] stx_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              stx_done,
  output logic              stx_status
);
  logic done_d, status_d, we_d;

  always_comb begin
    done_d   = stx_acc;
    status_d = stx_acc & ~commit;
    we_d     = commit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stx_done   <= 1'b0;
      stx_status <= 1'b0;
      mem_we     <= 1'b0;
    end else begin
      stx_done   <= done_d;
      stx_status <= status_d;
      mem_we     <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else if (stx_acc) begin
      mem_waddr <= stx_addr;
      mem_wdata <= stx_data;
    end
  end

  assert_we_has_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> stx_done && !stx_status);
endmodule

// File: rtl/xmon_top.sv
module xmon_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int GRAN_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ldx_valid,
  input  logic [ADDR_W-1:0] ldx_addr,
  input  logic              stx_valid,
  input  logic [ADDR_W-1:0] stx_addr,
  input  logic [DATA_W-1:0] stx_data,
  input  logic              clrx,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              stx_done,
  output logic              stx_status
);
  logic clr_acc, stx_acc, ldx_acc, hit, armed, commit;

  xmon_arb u_arb (
    .ldx_valid (ldx_valid),
    .stx_valid (stx_valid),
    .clrx      (clrx),
    .clr_acc   (clr_acc),
    .stx_acc   (stx_acc),
    .ldx_acc   (ldx_acc)
  );

  xmon_tag #(.ADDR_W(ADDR_W), .GRAN_W(GRAN_W)) u_tag (
    .clk      (clk),
    .rst_n    (rst_n),
    .ldx_acc  (ldx_acc),
    .ldx_addr (ldx_addr),
    .stx_addr (stx_addr),
    .hit      (hit)
  );

  xmon_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_acc (clr_acc),
    .stx_acc (stx_acc),
    .ldx_acc (ldx_acc),
    .hit     (hit),
    .armed   (armed),
    .commit  (commit)
  );

  xmon_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .stx_acc    (stx_acc),
    .commit     (commit),
    .stx_addr   (stx_addr),
    .stx_data   (stx_data),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .stx_done   (stx_done),
    .stx_status (stx_status)
  );

  assert_open_store_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_valid && !clrx && !armed) |=> stx_done && stx_status && !mem_we);
  assert_done_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stx_valid && !clrx) |=> stx_done);
  assert_no_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stx_valid && !clrx) |=> !stx_done);
endmodule

// File: tb/xmon_top_bench.sv
module xmon_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int GRAN_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ldx_valid, stx_valid, clrx;
  logic [ADDR_W-1:0] ldx_addr, stx_addr;
  logic [DATA_W-1:0] stx_data;
  logic mem_we, stx_done, stx_status;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [DATA_W-1:0] mem [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  xmon_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_W(GRAN_W)) u_xmon_top (
    .clk(clk), .rst_n(rst_n),
    .ldx_valid(ldx_valid), .ldx_addr(ldx_addr),
    .stx_valid(stx_valid), .stx_addr(stx_addr), .stx_data(stx_data),
    .clrx(clrx),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .stx_done(stx_done), .stx_status(stx_status)
  );

  always @(posedge clk)
    if (mem_we) mem[mem_waddr[5:2]] <= mem_wdata;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_ldx(input logic [ADDR_W-1:0] a);
    ldx_valid = 1'b1; ldx_addr = a;
    @(negedge clk);
    ldx_valid = 1'b0;
  endtask

  task automatic do_clr();
    clrx = 1'b1;
    @(negedge clk);
    clrx = 1'b0;
  endtask

  // Issue a store-exclusive and check its response one cycle later.
  task automatic do_stx(input string req, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input bit exp_ok);
    stx_valid = 1'b1; stx_addr = a; stx_data = d;
    @(negedge clk);
    stx_valid = 1'b0;
    check(req, "stx_done", int'(stx_done), 1);
    check(req, "stx_status", int'(stx_status), exp_ok ? 0 : 1);
    check(req, "mem_we", int'(mem_we), exp_ok ? 1 : 0);
    if (exp_ok) begin
      check(req, "mem_waddr", int'(mem_waddr), int'(a));
      check(req, "mem_wdata", int'(mem_wdata), int'(d));
    end
  endtask

  task automatic t_reset();
    check("R1", "stx_done after reset", int'(stx_done), 0);
    check("R1", "mem_we after reset", int'(mem_we), 0);
    do_stx("R1", 12'h040, 16'h1111, 1'b0);
  endtask

  task automatic t_basic();
    do_ldx(12'h100);
    do_stx("R2", 12'h100, 16'hABCD, 1'b1);
    do_stx("R3", 12'h100, 16'h0001, 1'b0);
    do_stx("R4", 12'h200, 16'h0002, 1'b0);
  endtask

  task automatic t_pulse();
    do_ldx(12'h300);
    do_stx("R10", 12'h300, 16'h5A5A, 1'b1);
    check("R10", "stx_done one cycle", int'(stx_done), 1);
    idle();
    check("R10", "stx_done cleared", int'(stx_done), 0);
    check("R10", "mem_we cleared", int'(mem_we), 0);
  endtask

  task automatic t_retag();
    do_ldx(12'h100);
    do_ldx(12'h180);
    do_stx("R5 old tag", 12'h100, 16'h0003, 1'b0);
    do_ldx(12'h100);
    do_ldx(12'h180);
    do_stx("R5 new tag", 12'h180, 16'h0004, 1'b1);
  endtask

  task automatic t_mismatch();
    do_ldx(12'h100);
    do_stx("R6 miss", 12'h104, 16'h0005, 1'b0);
    do_stx("R6 after miss", 12'h100, 16'h0006, 1'b0);
  endtask

  task automatic t_granule();
    do_ldx(12'h101);
    do_stx("R7 same granule", 12'h103, 16'h0007, 1'b1);
  endtask

  task automatic t_clear();
    do_ldx(12'h100);
    do_clr();
    do_stx("R8", 12'h100, 16'h0008, 1'b0);
  endtask

  task automatic t_priority();
    // clrx with a store in the same cycle: store dropped, no done.
    do_ldx(12'h100);
    clrx = 1'b1; stx_valid = 1'b1; stx_addr = 12'h100; stx_data = 16'h0009;
    @(negedge clk);
    clrx = 1'b0; stx_valid = 1'b0;
    check("R9 clr beats stx", "stx_done", int'(stx_done), 0);
    check("R9 clr beats stx", "mem_we", int'(mem_we), 0);
    // store and load in the same cycle: load dropped, monitor stays open.
    do_ldx(12'h100);
    stx_valid = 1'b1; stx_addr = 12'h100; stx_data = 16'h000A;
    ldx_valid = 1'b1; ldx_addr = 12'h200;
    @(negedge clk);
    stx_valid = 1'b0; ldx_valid = 1'b0;
    check("R9 stx beats ldx", "stx_status", int'(stx_status), 0);
    do_stx("R9 dropped load", 12'h200, 16'h000B, 1'b0);
  endtask

  task automatic t_interleave();
    logic [DATA_W-1:0] v1, v2, v3;
    do_ldx(12'h020); v1 = mem[8];
    do_ldx(12'h020); v2 = mem[8];
    do_stx("R11 second path", 12'h020, v2 + 16'd1, 1'b1);
    do_stx("R11 first path", 12'h020, v1 + 16'd1, 1'b0);
    do_ldx(12'h020); v3 = mem[8];
    do_stx("R11 retry", 12'h020, v3 + 16'd1, 1'b1);
    idle();
    check("R11", "memory value", int'(mem[8]), 32);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    mem[8] = 16'd30;
    rst_n = 1'b0; ldx_valid = 1'b0; stx_valid = 1'b0; clrx = 1'b0;
    ldx_addr = '0; stx_addr = '0; stx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle();
    t_reset();
    t_basic();
    t_pulse();
    t_retag();
    t_mismatch();
    t_granule();
    t_clear();
    t_priority();
    t_interleave();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule